// File: doc/BRIEF.md
# PHY Discovery and Link Sequencer

This block brings an Ethernet PHY into service without software. It sits in front of a management-bus read engine that does the serial wire work. It sends single register reads through a command/response pair. First it walks the management addresses looking for the first device that answers. It then forms that device's 32-bit identifier from two reads and looks the identifier up in a small table of known parts, which the chip sets up on an input bus. Last, it polls the control and status registers until the link is usable.

A scan is made of several passes with a fixed settling wait between them, so a PHY that is still in its own reset has time to wake up. Once a PHY has been found, its address is kept. Later start requests go straight to link polling and skip the scan. The results are the address, the identifier, whether the identifier is known and its table slot, a link-up flag and two error flags. All of them stay valid while `done` is high.

Top module: `phy_link_seq`

## Requirements
- R1: Within a pass, identifier-high reads (register 2) go to addresses 0, 1, 2 and upward in order, and the scan stops at the lowest address that answers. That address is reported on `phy_addr` with `phy_found` high.
- R2: A register-2 reply of 0xFFFF marks the address as empty, and the next address is tried. An identifier whose upper half is 0xFFFF is never reported as found.
- R3: After a valid register-2 reply, register 3 of the same address is read, and `phy_id` = {register-2 value, register-3 value}.
- R4: At most NUM_PASS passes are made, each over all NUM_ADDR addresses. No wait comes before the first pass. Before each later pass the block waits PASS_WAIT_MS × CYC_PER_MS clock cycles, so every later pass starts at least that long after the previous pass's last read.
- R5: If every pass finds nothing, `done` and `err_no_phy` go high, `phy_found` stays low and no control or status read is issued.
- R6: Table slot i sits at `id_table[32*i +: 32]`. Slots are searched from slot 0 upward, and the first slot equal to the identifier sets `id_known`=1 and `id_index`=i. A slot holding zero ends the table, so slots after it are never matched. An identifier with no match gives `id_known`=0 but is still reported as found.
- R7: The control register (register 0) is read and then the status register (register 1). If control bit 12 is set, the link is good only when status bits 5 and 2 are both 1. Otherwise status bit 2 alone decides. A good link ends the run with `link_up`=1.
- R8: Each control/status pair counts as one try. If LINK_TRIES tries all fail, the run ends with `err_link_timeout`=1 after exactly LINK_TRIES status reads. A good result on the last try is a link-up, not a timeout.
- R9: Once a PHY has been found, a later `start` reuses the stored address. Its first command is a control read to that address, and no register-2 read is made.
- R10: `cmd_valid` is a one-cycle pulse, and no new command is issued until the response to the previous one has arrived.
- R11: After reset, `busy`, `done`, `cmd_valid`, `phy_found`, `link_up` and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken when idle or done) |
| id_table | input | TBL_DEPTH*32 | Known-identifier table, slot i at bits 32*i+31..32*i |
| cmd_valid | output | 1 | One-cycle read command pulse |
| cmd_phy | output | ADDR_W | Management address of the command |
| cmd_reg | output | 5 | Register number of the command |
| rsp_valid | input | 1 | Read data valid, one cycle |
| rsp_data | input | 16 | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, results valid |
| phy_found | output | 1 | A PHY address is stored |
| phy_addr | output | ADDR_W | Stored or current address |
| phy_id | output | 32 | Assembled identifier |
| id_known | output | 1 | Identifier matched a table slot |
| id_index | output | IDX_W | Matching slot |
| link_up | output | 1 | Link judged good |
| err_no_phy | output | 1 | No PHY after all passes |
| err_link_timeout | output | 1 | Link tries exhausted |

## Verification
Two decisions can land on the same response cycle. An empty reply at the last address of the last pass ends both the address walk and the pass count. A good status on the last allowed try meets the retry limit. The bench provokes the first with no PHY model, checking that exactly NUM_PASS × NUM_ADDR identifier reads occur before `err_no_phy`. It provokes the second with a PHY whose link comes good on the final try, expecting `link_up` and no timeout. A third vector puts a PHY at the very last address and lets it wake only on a late pass. In that vector the wait between passes is measured from the command stream.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_ID_HI,
      ST_ID_LO,
      ST_MATCH,
      ST_CTRL,
      ST_STAT,
      ST_DONE
   } seq_st_t;

   localparam logic [4:0]  REG_CTRL  = 5'd0;
   localparam logic [4:0]  REG_STAT  = 5'd1;
   localparam logic [4:0]  REG_ID_HI = 5'd2;
   localparam logic [4:0]  REG_ID_LO = 5'd3;
   localparam logic [15:0] EMPTY_READ = 16'hFFFF;

   localparam int CTRL_AN_BIT  = 12;
   localparam int STAT_ANC_BIT = 5;
   localparam int STAT_LNK_BIT = 2;

endpackage

// File: rtl/phy_seq_wait.sv
module phy_seq_wait #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int CNT_W = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad
         $error("phy_seq_wait: CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= CNT_W'(CYCLES - 1);
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = run_q && (cnt_q == '0);
endmodule

// File: rtl/phy_seq_idmatch.sv
module phy_seq_idmatch #(
   parameter int DEPTH = 4,
   parameter int IDX_W = 2
) (
   input  logic [31:0]         id,
   input  logic [DEPTH*32-1:0] tbl,
   output logic                hit,
   output logic [IDX_W-1:0]    idx
);
   logic [DEPTH-1:0] live;
   logic [DEPTH-1:0] eq;

   generate
      if (DEPTH < 2) begin : g_bad
         $error("phy_seq_idmatch: DEPTH must be at least 2");
      end
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         if (g == 0) begin : g_first
            assign live[g] = (tbl[31:0] != 32'd0);
         end else begin : g_next
            assign live[g] = live[g-1] && (tbl[g*32 +: 32] != 32'd0);
         end
         assign eq[g] = live[g] && (tbl[g*32 +: 32] == id);
      end
   endgenerate

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (eq[i]) begin
            hit = 1'b1;
            idx = i[IDX_W-1:0];
         end
      end
   end
endmodule

// File: rtl/phy_seq_linkeval.sv
module phy_seq_linkeval #(
   parameter bit HONOUR_AN = 1'b1
) (
   input  logic an_enabled,
   input  logic st_an_done,
   input  logic st_link,
   output logic good
);
   generate
      if (HONOUR_AN) begin : g_an
         assign good = st_link && (!an_enabled || st_an_done);
      end else begin : g_plain
         logic unused_an;
         assign unused_an = an_enabled ^ st_an_done;
         assign good = st_link;
      end
   endgenerate
endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
   import phy_seq_pkg::*;
#(
   parameter int NUM_ADDR     = 32,
   parameter int NUM_PASS     = 11,
   parameter int PASS_WAIT_MS = 10,
   parameter int CYC_PER_MS   = 100000,
   parameter int LINK_TRIES   = 1000,
   parameter int TBL_DEPTH    = 8,
   parameter bit HONOUR_AN    = 1'b1,
   localparam int ADDR_W      = $clog2(NUM_ADDR),
   localparam int IDX_W       = $clog2(TBL_DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [TBL_DEPTH*32-1:0] id_table,
   output logic                    cmd_valid,
   output logic [ADDR_W-1:0]       cmd_phy,
   output logic [4:0]              cmd_reg,
   input  logic                    rsp_valid,
   input  logic [15:0]             rsp_data,
   output logic                    busy,
   output logic                    done,
   output logic                    phy_found,
   output logic [ADDR_W-1:0]       phy_addr,
   output logic [31:0]             phy_id,
   output logic                    id_known,
   output logic [IDX_W-1:0]        id_index,
   output logic                    link_up,
   output logic                    err_no_phy,
   output logic                    err_link_timeout
);
   localparam int WAIT_CYC = PASS_WAIT_MS * CYC_PER_MS;
   localparam int PASS_W   = $clog2(NUM_PASS + 1);
   localparam int TRY_W    = $clog2(LINK_TRIES + 1);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_ADDR - 1);
   localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NUM_PASS - 1);
   localparam logic [TRY_W-1:0]  LAST_TRY  = TRY_W'(LINK_TRIES - 1);

   generate
      if (NUM_ADDR < 2 || NUM_ADDR > 32) begin : g_bad_addr
         $error("phy_link_seq: NUM_ADDR must be 2..32");
      end
      if (NUM_PASS < 1) begin : g_bad_pass
         $error("phy_link_seq: NUM_PASS must be at least 1");
      end
      if (LINK_TRIES < 1) begin : g_bad_try
         $error("phy_link_seq: LINK_TRIES must be at least 1");
      end
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("phy_link_seq: pass wait must be at least one cycle");
      end
   endgenerate

   seq_st_t           st_q;
   logic              sent_q;
   logic [ADDR_W-1:0] addr_q;
   logic [PASS_W-1:0] pass_q;
   logic [TRY_W-1:0]  try_q;
   logic [15:0]       id_hi_q, id_lo_q;
   logic              an_q, found_q, hit_q, link_q, nophy_q, tmo_q;
   logic [IDX_W-1:0]  idx_q;

   logic              rd_state, rsp_ok, empty_rsp, wait_load, wait_done;
   logic              m_hit, good;
   logic [IDX_W-1:0]  m_idx;

   assign rd_state = (st_q == ST_ID_HI) || (st_q == ST_ID_LO) ||
                     (st_q == ST_CTRL)  || (st_q == ST_STAT);
   assign rsp_ok    = rsp_valid && sent_q;
   assign empty_rsp = (rsp_data == EMPTY_READ);
   assign wait_load = (st_q == ST_ID_HI) && rsp_ok && empty_rsp &&
                      (addr_q == LAST_ADDR) && (pass_q != LAST_PASS);

   phy_seq_wait #(.CYCLES(WAIT_CYC)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wait_load),
      .expired (wait_done)
   );

   phy_seq_idmatch #(.DEPTH(TBL_DEPTH), .IDX_W(IDX_W)) u_match (
      .id  ({id_hi_q, id_lo_q}),
      .tbl (id_table),
      .hit (m_hit),
      .idx (m_idx)
   );

   phy_seq_linkeval #(.HONOUR_AN(HONOUR_AN)) u_link (
      .an_enabled (an_q),
      .st_an_done (rsp_data[STAT_ANC_BIT]),
      .st_link    (rsp_data[STAT_LNK_BIT]),
      .good       (good)
   );

   always_comb begin
      unique case (st_q)
         ST_ID_HI: cmd_reg = REG_ID_HI;
         ST_ID_LO: cmd_reg = REG_ID_LO;
         ST_STAT:  cmd_reg = REG_STAT;
         default:  cmd_reg = REG_CTRL;
      endcase
   end

   assign cmd_valid = rd_state && !sent_q;
   assign cmd_phy   = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sent_q <= 1'b0;
      end else if (cmd_valid) begin
         sent_q <= 1'b1;
      end else if (rsp_valid) begin
         sent_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         pass_q  <= '0;
         try_q   <= '0;
         id_hi_q <= '0;
         id_lo_q <= '0;
         an_q    <= 1'b0;
         found_q <= 1'b0;
         hit_q   <= 1'b0;
         idx_q   <= '0;
         link_q  <= 1'b0;
         nophy_q <= 1'b0;
         tmo_q   <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  link_q  <= 1'b0;
                  nophy_q <= 1'b0;
                  tmo_q   <= 1'b0;
                  try_q   <= '0;
                  if (found_q) begin
                     st_q <= ST_CTRL;
                  end else begin
                     addr_q <= '0;
                     pass_q <= '0;
                     hit_q  <= 1'b0;
                     idx_q  <= '0;
                     st_q   <= ST_ID_HI;
                  end
               end
            end
            ST_WAIT: begin
               if (wait_done) st_q <= ST_ID_HI;
            end
            ST_ID_HI: begin
               if (rsp_ok) begin
                  if (!empty_rsp) begin
                     id_hi_q <= rsp_data;
                     st_q    <= ST_ID_LO;
                  end else if (addr_q != LAST_ADDR) begin
                     addr_q <= addr_q + 1'b1;
                  end else if (pass_q == LAST_PASS) begin
                     nophy_q <= 1'b1;
                     st_q    <= ST_DONE;
                  end else begin
                     addr_q <= '0;
                     pass_q <= pass_q + 1'b1;
                     st_q   <= ST_WAIT;
                  end
               end
            end
            ST_ID_LO: begin
               if (rsp_ok) begin
                  id_lo_q <= rsp_data;
                  found_q <= 1'b1;
                  st_q    <= ST_MATCH;
               end
            end
            ST_MATCH: begin
               hit_q <= m_hit;
               idx_q <= m_idx;
               st_q  <= ST_CTRL;
            end
            ST_CTRL: begin
               if (rsp_ok) begin
                  an_q <= rsp_data[CTRL_AN_BIT];
                  st_q <= ST_STAT;
               end
            end
            ST_STAT: begin
               if (rsp_ok) begin
                  if (good) begin
                     link_q <= 1'b1;
                     st_q   <= ST_DONE;
                  end else if (try_q == LAST_TRY) begin
                     tmo_q <= 1'b1;
                     st_q  <= ST_DONE;
                  end else begin
                     try_q <= try_q + 1'b1;
                     st_q  <= ST_CTRL;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy             = (st_q != ST_IDLE) && (st_q != ST_DONE);
   assign done             = (st_q == ST_DONE);
   assign phy_found        = found_q;
   assign phy_addr         = addr_q;
   assign phy_id           = {id_hi_q, id_lo_q};
   assign id_known         = hit_q;
   assign id_index         = idx_q;
   assign link_up          = link_q;
   assign err_no_phy       = nophy_q;
   assign err_link_timeout = tmo_q;
endmodule

// File: rtl/phy_seq_chk.sv
module phy_seq_chk #(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              cmd_valid,
   input logic              done,
   input logic              phy_found,
   input logic [ADDR_W-1:0] phy_addr,
   input logic [31:0]       phy_id,
   input logic              link_up,
   input logic              err_no_phy,
   input logic              err_link_timeout
);
   AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid); // R10

   AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cmd_valid); // R5

   AST_NOPHY_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      err_no_phy |-> (done && !phy_found && !link_up)); // R5

   AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_no_phy && err_link_timeout)); // R8

   AST_LINK_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      link_up |-> (done && !err_link_timeout)); // R7

   AST_FOUND_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      phy_found |-> (phy_id[31:16] != 16'hFFFF)); // R2

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable(phy_addr)); // R9
endmodule

bind phy_link_seq phy_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .start            (start),
   .cmd_valid        (cmd_valid),
   .done             (done),
   .phy_found        (phy_found),
   .phy_addr         (phy_addr),
   .phy_id           (phy_id),
   .link_up          (link_up),
   .err_no_phy       (err_no_phy),
   .err_link_timeout (err_link_timeout)
);

// File: tb/test_phy_link_seq.sv
module test_phy_link_seq;
   localparam int NUM_ADDR = 32;
   localparam int NUM_PASS = 11;
   localparam int WAIT_MS  = 10;
   localparam int CPMS     = 5;
   localparam int TRIES    = 8;
   localparam int DEPTH    = 4;
   localparam int LAT      = 3;
   localparam int WAIT_CYC = WAIT_MS * CPMS;

   typedef struct packed {
      logic [5:0]  addr;      // 32 = no PHY
      logic [3:0]  appear;    // first pass (0-based) in which PHY answers
      logic [15:0] id_hi;
      logic [15:0] id_lo;
      logic [15:0] ctrl;
      logic [15:0] stat;
      logic [7:0]  link_after;
      logic        exp_known;
      logic [1:0]  exp_idx;
      logic        exp_nophy;
      logic        exp_tmo;
      logic [15:0] exp_hi_rd;
      logic [7:0]  exp_st_rd;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{6'd5,  4'd0,  16'h1111, 16'h2222, 16'h1000, 16'h0024, 8'd2, 1'b1, 2'd0, 1'b0, 1'b0, 16'd6,   8'd3},
      '{6'd0,  4'd0,  16'h3333, 16'h4444, 16'h0000, 16'h0004, 8'd0, 1'b1, 2'd1, 1'b0, 1'b0, 16'd1,   8'd1},
      '{6'd31, 4'd2,  16'h5555, 16'h6666, 16'h0000, 16'h0004, 8'd0, 1'b0, 2'd0, 1'b0, 1'b0, 16'd96,  8'd1},
      '{6'd32, 4'd0,  16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'd0, 1'b0, 2'd0, 1'b1, 1'b0, 16'd352, 8'd0},
      '{6'd7,  4'd0,  16'hABCD, 16'h0001, 16'h1000, 16'h0004, 8'd0, 1'b0, 2'd0, 1'b0, 1'b1, 16'd8,   8'd8},
      '{6'd3,  4'd10, 16'h1111, 16'h2222, 16'h1000, 16'h0024, 8'd7, 1'b1, 2'd0, 1'b0, 1'b0, 16'd324, 8'd8}
   };

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n, start;
   logic [DEPTH*32-1:0] id_table;
   logic              cmd_valid, rsp_valid;
   logic [4:0]        cmd_phy, cmd_reg;
   logic [15:0]       rsp_data;
   logic              busy, done, phy_found, id_known, link_up, err_no_phy, err_link_timeout;
   logic [4:0]        phy_addr;
   logic [31:0]       phy_id;
   logic [1:0]        id_index;

   phy_link_seq #(
      .NUM_ADDR(NUM_ADDR), .NUM_PASS(NUM_PASS), .PASS_WAIT_MS(WAIT_MS),
      .CYC_PER_MS(CPMS), .LINK_TRIES(TRIES), .TBL_DEPTH(DEPTH), .HONOUR_AN(1'b1)
   ) i_phy_link_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .id_table(id_table),
      .cmd_valid(cmd_valid), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .busy(busy), .done(done), .phy_found(phy_found), .phy_addr(phy_addr),
      .phy_id(phy_id), .id_known(id_known), .id_index(id_index),
      .link_up(link_up), .err_no_phy(err_no_phy), .err_link_timeout(err_link_timeout)
   );

   // PHY model behind the read engine
   vec_t        mv;
   int          cyc, lat, pass_seen, hi_rd, st_rd, t_last, gap_min;
   logic        overlap, saw_last;
   logic        cap_first, first_taken;
   logic [4:0]  first_reg, first_phy;
   logic [15:0] q_data;
   int          pnum;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         rsp_valid <= 1'b0; rsp_data <= '0; lat <= 0; pass_seen <= 0;
         hi_rd <= 0; st_rd <= 0; overlap <= 1'b0; saw_last <= 1'b0;
         gap_min <= 1000000; first_taken <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         if (lat != 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
               rsp_valid <= 1'b1;
               rsp_data  <= q_data;
            end
         end
         if (cmd_valid) begin
            if (lat != 0) overlap <= 1'b1;
            lat <= LAT;
            if (cap_first && !first_taken) begin
               first_taken <= 1'b1;
               first_reg   <= cmd_reg;
               first_phy   <= cmd_phy;
            end
            case (cmd_reg)
               5'd2: begin
                  pnum = (cmd_phy == 5'd0) ? pass_seen + 1 : pass_seen;
                  if (!mv.addr[5] && cmd_phy == mv.addr[4:0] && pnum > int'(mv.appear))
                     q_data <= mv.id_hi;
                  else
                     q_data <= 16'hFFFF;
                  hi_rd <= hi_rd + 1;
                  if (cmd_phy == 5'd0) begin
                     pass_seen <= pass_seen + 1;
                     if (saw_last && (cyc - t_last) < gap_min) gap_min <= cyc - t_last;
                  end
                  if (cmd_phy == 5'd31) begin
                     saw_last <= 1'b1;
                     t_last   <= cyc;
                  end
               end
               5'd3: q_data <= mv.id_lo;
               5'd0: q_data <= mv.ctrl;
               default: begin
                  q_data <= (st_rd >= int'(mv.link_after)) ? mv.stat : (mv.stat & ~16'h0024);
                  st_rd  <= st_rd + 1;
               end
            endcase
         end
      end
   end

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk("run ends (watchdog)", {31'd0, done}, 32'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int hi0;
      rst_n = 1'b0; start = 1'b0; cap_first = 1'b0; cyc = 0;
      mv = VECS[0];
      id_table = {32'h5555_6666, 32'h0000_0000, 32'h3333_4444, 32'h1111_2222};
      do_reset();
      // R11 reset state
      chk("R11 busy", {31'd0, busy}, 32'd0);
      chk("R11 done", {31'd0, done}, 32'd0);
      chk("R11 cmd_valid", {31'd0, cmd_valid}, 32'd0);
      chk("R11 flags", {28'd0, phy_found, link_up, err_no_phy, err_link_timeout}, 32'd0);

      for (int v = 0; v < NV; v++) begin
         mv = VECS[v];
         do_reset();
         pulse_start();
         wait_done();
         chk("R5 err_no_phy", {31'd0, err_no_phy}, {31'd0, mv.exp_nophy});
         chk("R8 err_link_timeout", {31'd0, err_link_timeout}, {31'd0, mv.exp_tmo});
         chk("R1 phy_found", {31'd0, phy_found}, {31'd0, !mv.exp_nophy});
         chk("R1 R2 R4 id-high read count", hi_rd, {16'd0, mv.exp_hi_rd});
         chk("R8 status read count", st_rd, {24'd0, mv.exp_st_rd});
         chk("R10 no overlapping commands", {31'd0, overlap}, 32'd0);
         if (!mv.exp_nophy) begin
            chk("R1 phy_addr", {27'd0, phy_addr}, {26'd0, mv.addr});
            chk("R3 phy_id", phy_id, {mv.id_hi, mv.id_lo});
            chk("R6 id_known", {31'd0, id_known}, {31'd0, mv.exp_known});
            if (mv.exp_known) chk("R6 id_index", {30'd0, id_index}, {30'd0, mv.exp_idx});
            chk("R7 link_up", {31'd0, link_up}, {31'd0, !mv.exp_tmo});
         end else begin
            chk("R5 link_up low", {31'd0, link_up}, 32'd0);
         end
         if (mv.exp_nophy || mv.appear != 0) begin
            chk("R4 pass wait lower bound", {31'd0, gap_min >= WAIT_CYC}, 32'd1);
            chk("R4 pass wait upper bound", {31'd0, gap_min <= WAIT_CYC + LAT + 6}, 32'd1);
         end
      end

      // R9: restart after discovery (last vector left a PHY at address 3)
      hi0 = hi_rd;
      cap_first = 1'b1;
      pulse_start();
      wait_done();
      chk("R9 first command is control read", {27'd0, first_reg}, 32'd0);
      chk("R9 first command address", {27'd0, first_phy}, 32'd3);
      chk("R9 no id-high reads", hi_rd, hi0);
      chk("R9 link_up", {31'd0, link_up}, 32'd1);
      chk("R9 phy_addr kept", {27'd0, phy_addr}, 32'd3);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule